// File: doc/BRIEF.md
# Multichannel TDM Frame Packer with Channel Power-Down

This block builds the per-conversion output frame of a multichannel converter whose channels can each be shut off on their own. On every conversion-complete strobe it takes one parallel sample word per channel. It then presents an ordered array of slot words, a per-slot valid mask and the number of valid slots to a downstream serializer. All three outputs change together, on that strobe only.

Each channel has an active-low power-down line, and a short glitch on that line is filtered out. After a channel comes back up, it must sit out a warm-up of a fixed number of conversions before its data count as valid. That number depends on which serial format the serializer uses. Three packing modes decide how a missing channel appears in the frame. In fixed mode its slot keeps its place and carries zeros. In dynamic mode its slot is squeezed out. In discrete mode each channel keeps its own lane, and a missing channel reports zero. When every channel is down, a status flag asks the rest of the device to enter its global low-power state.

Top module: `tdm_frame_packer`

## Requirements
- R1: A channel enters power-down only after its `pwdn_n` bit has been sampled low on two consecutive clock edges. A single-cycle low pulse leaves the channel running, and its data keep appearing in the frame.
- R2: A powered-down channel leaves power-down on the first clock edge at which its `pwdn_n` bit is sampled high, and it starts its warm-up count there.
- R3: After power-up, a channel counts conversion strobes. With `fmt_fs` = 0 (SPI) its data first become valid in the frame produced by the 130th strobe. With `fmt_fs` = 1 (frame-sync) this happens on the 129th strobe. Until then the channel is treated as having no data.
- R4: Powering any channel up or down never changes the data or the slot positions of channels that are already running.
- R5: With `pack_mode` = 2'b00 (fixed), slot k carries channel k. A channel that is down or warming up carries all-zero data. All slots are valid, and `active_slots` equals the channel count.
- R6: With `pack_mode` = 2'b01 (dynamic), the valid channels fill slots 0 upward in ascending channel order. The valid mask is contiguous from bit 0, and unused slots carry zero.
- R7: In dynamic mode, a warming-up channel stays out of the packed frame until its warm-up completes. The frame then grows to include it at its ordered position.
- R8: With `pack_mode` = 2'b10 or 2'b11 (discrete), slot k carries channel k, or zero when the channel has no valid data. Valid bit k is set only for a channel with valid data.
- R9: `all_down` is high exactly while every channel is in power-down. It falls on the first edge at which any `pwdn_n` bit is sampled high, and the frame outputs stay driven while it is high.
- R10: Channels that leave power-down on the same edge complete their warm-up on the same strobe and join the frame together.
- R11: A channel's warm-up count restarts from zero each time the channel re-enters power-down, so a partial warm-up is never credited.
- R12: `slot_data`, `slot_valid` and `active_slots` change only on a clock edge with `conv_strobe` high. `active_slots` always equals the number of set bits in `slot_valid`.
- R13: After reset, all channels are treated as running and warmed up. The frame outputs are zero, the valid mask is empty, and `all_down` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwdn_n | input | NCH | Per-channel active-low power-down request |
| conv_strobe | input | 1 | Conversion-complete strobe, one cycle per conversion |
| sample_in | input | NCH*W | Channel k sample in bits [k*W +: W] |
| pack_mode | input | 2 | 00 fixed, 01 dynamic, 10/11 discrete |
| fmt_fs | input | 1 | 0 selects the SPI warm-up length, 1 selects frame-sync |
| slot_data | output | NCH*W | Slot k word in bits [k*W +: W] |
| slot_valid | output | NCH | Per-slot valid mask |
| active_slots | output | $clog2(NCH+1) | Number of valid slots |
| all_down | output | 1 | All channels powered down |

## Verification
The bench drives a one-cycle low pulse on a power-down line and then checks that the channel's data are still present. A filter that trips on one sample would zero that slot and force a full warm-up. Warm-up is checked on both sides of the limit, at the 129th and 130th strobes for SPI and at the 128th and 129th for frame-sync. An off-by-one counter, or a frame that lags the count by one register, shows up as a channel that appears one conversion early or late. A channel is also powered down partway through its warm-up and then brought back up. A counter that is not cleared would let that channel rejoin too soon. Dynamic packing is checked with holes in the middle of the channel order, with two channels rejoining together, and with every channel down. This exposes a packer that leaves gaps, reorders channels, or miscounts the active slots.

// File: rtl/tdm_frame_packer.sv
module tdm_frame_packer #(
  parameter int NCH      = 8,
  parameter int W        = 24,
  parameter int WARM_SPI = 130,
  parameter int WARM_FS  = 129,
  localparam int AW = $clog2(NCH + 1),
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW = $clog2(((WARM_SPI > WARM_FS) ? WARM_SPI : WARM_FS) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pwdn_n,
  input  logic             conv_strobe,
  input  logic [NCH*W-1:0] sample_in,
  input  logic [1:0]       pack_mode,
  input  logic             fmt_fs,
  output logic [NCH*W-1:0] slot_data,
  output logic [NCH-1:0]   slot_valid,
  output logic [AW-1:0]    active_slots,
  output logic             all_down
);

  logic [NCH-1:0] low_q, down_q, ready_q, ready_nx;
  logic [CW-1:0]  cnt_q [NCH];
  logic [W-1:0]   smp [NCH];
  logic [W-1:0]   slot_q [NCH];
  logic [W-1:0]   nx_slot [NCH];
  logic [NCH-1:0] nx_valid;
  logic [AW-1:0]  nx_cnt;
  logic [IW-1:0]  pos;

  wire [CW-1:0] lim = fmt_fs ? CW'(WARM_FS) : CW'(WARM_SPI);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign smp[i] = sample_in[i*W +: W];
    assign slot_data[i*W +: W] = slot_q[i];
    assign ready_nx[i] = !down_q[i] &&
                         (ready_q[i] || (conv_strobe && (cnt_q[i] >= lim - CW'(1))));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        low_q[i]   <= 1'b0;
        down_q[i]  <= 1'b0;
        ready_q[i] <= 1'b1;
        cnt_q[i]   <= '0;
      end else begin
        low_q[i]   <= !pwdn_n[i];
        down_q[i]  <= !pwdn_n[i] && (low_q[i] || down_q[i]);
        ready_q[i] <= ready_nx[i];
        if (down_q[i])
          cnt_q[i] <= '0;
        else if (conv_strobe && !ready_q[i] && cnt_q[i] < lim)
          cnt_q[i] <= cnt_q[i] + CW'(1);
      end
    end
  end

  always_comb begin
    pos      = '0;
    nx_valid = '0;
    for (int i = 0; i < NCH; i++) nx_slot[i] = '0;
    for (int i = 0; i < NCH; i++) begin
      case (pack_mode)
        2'b00: begin
          nx_valid[i] = 1'b1;
          if (ready_nx[i]) nx_slot[i] = smp[i];
        end
        2'b01: begin
          if (ready_nx[i]) begin
            nx_slot[pos]  = smp[i];
            nx_valid[pos] = 1'b1;
            pos = pos + IW'(1);
          end
        end
        default: begin
          if (ready_nx[i]) begin
            nx_slot[i]  = smp[i];
            nx_valid[i] = 1'b1;
          end
        end
      endcase
    end
    nx_cnt = '0;
    for (int i = 0; i < NCH; i++) nx_cnt = nx_cnt + AW'(nx_valid[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) slot_q[i] <= '0;
      slot_valid   <= '0;
      active_slots <= '0;
    end else if (conv_strobe) begin
      for (int i = 0; i < NCH; i++) slot_q[i] <= nx_slot[i];
      slot_valid   <= nx_valid;
      active_slots <= nx_cnt;
    end
  end

  assign all_down = &down_q;

endmodule

// File: rtl/tdm_frame_packer_chk.sv
module tdm_frame_packer_chk #(
  parameter int NCH = 8,
  parameter int W   = 24,
  parameter int AW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   pwdn_n,
  input logic             conv_strobe,
  input logic [1:0]       pack_mode,
  input logic [NCH*W-1:0] slot_data,
  input logic [NCH-1:0]   slot_valid,
  input logic [AW-1:0]    active_slots,
  input logic             all_down,
  input logic [NCH-1:0]   down_q,
  input logic [NCH-1:0]   ready_q
);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R1
    down_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(down_q[i]) |-> ($past(!pwdn_n[i]) && $past(!pwdn_n[i], 2)));
    // R2
    down_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwdn_n[i] |=> !down_q[i]);
    // R3
    down_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      down_q[i] |=> !ready_q[i]);
  end

  // R12
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_strobe |=> ($stable(slot_data) && $stable(slot_valid) && $stable(active_slots)));
  // R12
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_slots == AW'($countones(slot_valid)));
  // R5
  fixed_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && pack_mode == 2'b00) |=> (&slot_valid));
  // R6
  dyn_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && pack_mode == 2'b01) |=> ((NCH'(slot_valid + 1'b1) & slot_valid) == '0));
  // R9
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwdn_n != '0) |=> !all_down);

endmodule

bind tdm_frame_packer tdm_frame_packer_chk #(.NCH(NCH), .W(W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwdn_n(pwdn_n), .conv_strobe(conv_strobe),
  .pack_mode(pack_mode), .slot_data(slot_data), .slot_valid(slot_valid),
  .active_slots(active_slots), .all_down(all_down),
  .down_q(down_q), .ready_q(ready_q)
);

// File: tb/tdm_frame_packer_tb.sv
module tdm_frame_packer_tb_top;
  localparam int NCH = 8;
  localparam int W   = 24;
  localparam int AW  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   pwdn_n = '1;
  logic             conv_strobe = 1'b0;
  logic [NCH*W-1:0] sample_in = '0;
  logic [1:0]       pack_mode = 2'b00;
  logic             fmt_fs = 1'b0;
  logic [NCH*W-1:0] slot_data;
  logic [NCH-1:0]   slot_valid;
  logic [AW-1:0]    active_slots;
  logic             all_down;

  int errors = 0;
  int checks = 0;
  logic [1:0] last_mode;
  logic [7:0] last_rdy;
  int         last_seed;

  always #5 clk = ~clk;

  tdm_frame_packer dut_i (
    .clk(clk), .rst_n(rst_n), .pwdn_n(pwdn_n), .conv_strobe(conv_strobe),
    .sample_in(sample_in), .pack_mode(pack_mode), .fmt_fs(fmt_fs),
    .slot_data(slot_data), .slot_valid(slot_valid),
    .active_slots(active_slots), .all_down(all_down)
  );

  function automatic logic [W-1:0] smp(int seed, int ch);
    return {8'(seed), 8'(ch), 8'hC3};
  endfunction

  function automatic logic [NCH*W-1:0] exp_data(logic [1:0] m, logic [7:0] rdy, int seed);
    logic [NCH*W-1:0] d = '0;
    int p = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m == 2'b01) begin
        if (rdy[c]) begin d[p*W +: W] = smp(seed, c); p++; end
      end else if (rdy[c]) d[c*W +: W] = smp(seed, c);
    end
    return d;
  endfunction

  function automatic logic [NCH-1:0] exp_valid(logic [1:0] m, logic [7:0] rdy);
    if (m == 2'b00) return '1;
    if (m == 2'b01) return NCH'((9'd1 << $countones(rdy)) - 9'd1);
    return rdy;
  endfunction

  task automatic chk(string req, string what, logic [NCH*W-1:0] act, logic [NCH*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_frame(string req, logic [1:0] m, logic [7:0] rdy, int seed);
    logic [NCH-1:0] v = exp_valid(m, rdy);
    chk(req, "slot_data", slot_data, exp_data(m, rdy, seed));
    chk(req, "slot_valid", (NCH*W)'(slot_valid), (NCH*W)'(v));
    chk(req, "active_slots", (NCH*W)'(active_slots), (NCH*W)'($countones(v)));
    last_mode = m; last_rdy = rdy; last_seed = seed;
  endtask

  task automatic strobe(int seed);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) sample_in[c*W +: W] = smp(seed, c);
    conv_strobe = 1'b1;
    @(negedge clk);
    conv_strobe = 1'b0;
  endtask

  task automatic power_down(logic [NCH-1:0] m);
    @(negedge clk);
    pwdn_n = pwdn_n & ~m;
    repeat (3) @(negedge clk);
  endtask

  task automatic power_up(logic [NCH-1:0] m);
    @(negedge clk);
    pwdn_n = pwdn_n | m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13", "slot_data", slot_data, '0);
    chk("R13", "slot_valid", (NCH*W)'(slot_valid), '0);
    chk("R13", "active_slots", (NCH*W)'(active_slots), '0);
    chk("R13", "all_down", (NCH*W)'(all_down), '0);
  endtask

  task automatic t_fixed_all();
    pack_mode = 2'b00;
    strobe(1);
    check_frame("R5", 2'b00, 8'hFF, 1);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    pwdn_n[2] = 1'b0;
    @(negedge clk);
    pwdn_n[2] = 1'b1;
    strobe(2);
    check_frame("R1", 2'b00, 8'hFF, 2);
  endtask

  task automatic t_down_modes();
    power_down(8'h24);
    pack_mode = 2'b00; strobe(3); check_frame("R5", 2'b00, 8'hDB, 3);
    pack_mode = 2'b01; strobe(4); check_frame("R6", 2'b01, 8'hDB, 4);
    pack_mode = 2'b10; strobe(5); check_frame("R8", 2'b10, 8'hDB, 5);
  endtask

  task automatic t_hold();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) sample_in[c*W +: W] = smp(99, c);
    pack_mode = 2'b01;
    repeat (3) @(negedge clk);
    check_frame("R12", last_mode, last_rdy, last_seed);
  endtask

  task automatic t_warm_spi();
    fmt_fs = 1'b0; pack_mode = 2'b01;
    power_up(8'h24);
    for (int n = 1; n <= 130; n++) begin
      strobe(n);
      if (n == 1)   check_frame("R4", 2'b01, 8'hDB, n);
      if (n == 129) check_frame("R3", 2'b01, 8'hDB, n);
      if (n == 130) check_frame("R7 R10", 2'b01, 8'hFF, n);
    end
  endtask

  task automatic t_warm_fs();
    fmt_fs = 1'b1; pack_mode = 2'b01;
    power_down(8'h01);
    strobe(7); check_frame("R6", 2'b01, 8'hFE, 7);
    power_up(8'h01);
    for (int n = 1; n <= 129; n++) begin
      strobe(n);
      if (n == 128) check_frame("R3", 2'b01, 8'hFE, n);
      if (n == 129) check_frame("R3", 2'b01, 8'hFF, n);
    end
  endtask

  task automatic t_reentry();
    fmt_fs = 1'b0; pack_mode = 2'b01;
    power_down(8'h08);
    power_up(8'h08);
    for (int n = 1; n <= 60; n++) strobe(n);
    check_frame("R11", 2'b01, 8'hF7, 60);
    power_down(8'h08);
    power_up(8'h08);
    for (int n = 1; n <= 130; n++) begin
      strobe(n);
      if (n == 129) check_frame("R11", 2'b01, 8'hF7, n);
      if (n == 130) check_frame("R11", 2'b01, 8'hFF, n);
    end
  endtask

  task automatic t_all_down();
    pack_mode = 2'b01;
    power_down('1);
    chk("R9", "all_down high", (NCH*W)'(all_down), (NCH*W)'(1));
    strobe(11); check_frame("R9", 2'b01, 8'h00, 11);
    pack_mode = 2'b00; strobe(12); check_frame("R9", 2'b00, 8'h00, 12);
    @(negedge clk);
    pwdn_n[4] = 1'b1;
    @(negedge clk);
    chk("R2 R9", "all_down low", (NCH*W)'(all_down), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed_all();
    t_glitch();
    t_down_modes();
    t_hold();
    t_warm_spi();
    t_warm_fs();
    t_reentry();
    t_all_down();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule